// File: doc/BRIEF.md
# SM4 Byte-Sliced Round Step Unit

This unit performs one byte-wide step of the SM4 cipher's mixing transform. One byte of the operand word is chosen, run through the SM4 substitution box, and zero-extended to a 32-bit word. That word then goes through one of two linear layers: the data-round layer or the key-expansion layer. The result is rotated left by eight times the byte index and XORed into an accumulator word. If four steps are issued with byte indices 0, 1, 2 and 3, and each result is fed back as the next accumulator, the chain gives the full round function x0 XOR T(x1 XOR x2 XOR x3 XOR rk).

The operation is selected by a 7-bit function code taken from the instruction word. Bits 6:5 give the byte index. Bit 1 chooses the key-expansion layer. Bits 4:0 must equal 11000 or 11010 in binary. Every other code raises an illegal flag, and the accumulator then passes through unchanged. The result is registered, and the latency is always one cycle.

Top module: `sm4_byte_round`

## Requirements
- R1: The byte processed is opnd_a bits [8k+7:8k], where k is the byte index. It passes through the SM4 substitution box, which maps 0x00 to 0xD6 and 0x01 to 0x90.
- R2: With funct7 bit 1 clear, the substituted byte b (zero-extended to 32 bits) becomes b ^ rotl(b,2) ^ rotl(b,10) ^ rotl(b,18) ^ rotl(b,24).
- R3: With funct7 bit 1 set, the substituted byte b (zero-extended) becomes b ^ rotl(b,13) ^ rotl(b,23).
- R4: The transformed word is rotated left by 8*k bits and XORed with acc_x to form out_result.
- R5: The byte index k is funct7[6:5]. The legal codes are 0x18, 0x38, 0x58 and 0x78 for data-round steps and 0x1A, 0x3A, 0x5A and 0x7A for key-expansion steps. A legal code gives out_illegal = 0.
- R6: For any other funct7 value, out_illegal = 1 and out_result equals acc_x unchanged.
- R7: out_valid is high in exactly the cycle after a cycle with in_valid high, whatever the operand values, including on back-to-back issue.
- R8: While in_valid is low, out_result holds its value, out_illegal is 0 and input changes have no effect.
- R9: Four chained steps with k = 0, 1, 2, 3 produce x0 ^ T(A) for the chosen linear layer, where T substitutes all four bytes of A.
- R10: After reset, out_valid, out_illegal and out_result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe for one step |
| funct7 | input | 7 | Function code: byte index, layer choice, legality |
| acc_x | input | WORD_W | Accumulator word |
| opnd_a | input | WORD_W | Operand word supplying the byte |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| out_result | output | WORD_W | Registered step result |
| out_illegal | output | 1 | Issued code was not a legal encoding |

## Verification
The assertions assume that in_valid and funct7 are known values whenever reset is released. They also assume that in_valid is low during reset, so the first post-reset comparison of out_valid against the previous issue is meaningful. The bench drives every input half a clock away from the capturing edge and keeps in_valid low throughout reset. The sweep covers every byte value at every index in both layers, and all 128 function codes, so both legal and illegal decodes are reached without leaving those assumptions.

// File: rtl/sm4bs_pkg.sv
package sm4bs_pkg;

   localparam int WORD_W = 32;
   localparam int BYTE_W = 8;

   typedef enum logic {
      LAYER_ROUND = 1'b0,
      LAYER_KEY   = 1'b1
   } sm4bs_layer_e;

   // low five bits of legal function codes
   localparam logic [4:0] CODE_LO_ROUND = 5'b11000;
   localparam logic [4:0] CODE_LO_KEY   = 5'b11010;

   localparam logic [7:0] AFFINE_C   = 8'hD3;
   localparam logic [7:0] FIELD_RED  = 8'hF5;   // x^8 = x^7+x^6+x^5+x^4+x^2+1

   function automatic logic [7:0] gf_mul(input logic [7:0] p, input logic [7:0] q);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = '0;
      sh  = p;
      for (int i = 0; i < 8; i++) begin
         if (q[i]) acc = acc ^ sh;
         sh = sh[7] ? ((sh << 1) ^ FIELD_RED) : (sh << 1);
      end
      return acc;
   endfunction

   function automatic logic [7:0] affine(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) begin
         r[i] = v[i] ^ v[(i + 1) % 8] ^ v[(i + 2) % 8] ^ v[(i + 5) % 8] ^ v[(i + 7) % 8];
      end
      return r ^ AFFINE_C;
   endfunction

   function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] w, input int unsigned n);
      int unsigned m;
      m = n % WORD_W;
      return (w << m) | (w >> ((WORD_W - m) % WORD_W));
   endfunction

endpackage

// File: rtl/sm4bs_decode.sv
module sm4bs_decode
   import sm4bs_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic [6:0]       code,
   output logic [SEL_W-1:0] lane_sel,
   output sm4bs_layer_e     layer,
   output logic             bad_code
);
   if (SEL_W != 2) begin : g_chk_sel
      $error("sm4bs_decode: SEL_W must be 2");
   end

   always_comb begin
      lane_sel = code[6:5];
      layer    = code[1] ? LAYER_KEY : LAYER_ROUND;
      bad_code = !((code[4:0] == CODE_LO_ROUND) || (code[4:0] == CODE_LO_KEY));
   end
endmodule

// File: rtl/sm4bs_sbox.sv
module sm4bs_sbox
   import sm4bs_pkg::*;
(
   input  logic [7:0] din,
   output logic [7:0] dout
);
   logic [7:0] pre;
   logic [7:0] inv;
   logic [7:0] pw;

   // inverse as z^254 = z^2 * z^4 * ... * z^128, fixed depth for every input
   always_comb begin
      pre = affine(din);
      pw  = pre;
      inv = 8'h01;
      for (int k = 1; k < 8; k++) begin
         pw  = gf_mul(pw, pw);
         inv = gf_mul(inv, pw);
      end
      dout = affine(inv);
   end
endmodule

// File: rtl/sm4bs_linear.sv
module sm4bs_linear
   import sm4bs_pkg::*;
#(
   parameter int W = WORD_W
) (
   input  logic [W-1:0]  b_in,
   input  sm4bs_layer_e  layer,
   output logic [W-1:0]  l_out
);
   if (W != 32) begin : g_chk_w
      $error("sm4bs_linear: rotation taps are defined for 32-bit words only");
   end

   logic [W-1:0] y_round;
   logic [W-1:0] y_key;

   always_comb begin
      y_round = b_in ^ rotl(b_in, 2) ^ rotl(b_in, 10) ^ rotl(b_in, 18) ^ rotl(b_in, 24);
      y_key   = b_in ^ rotl(b_in, 13) ^ rotl(b_in, 23);
      l_out   = (layer == LAYER_KEY) ? y_key : y_round;
   end

   // both layers are invertible: a nonzero input never maps to zero
   always_comb begin
      if (b_in != '0) begin
         assert_lin_invertible_R3: assert (y_key != '0 && y_round != '0);
      end
   end
endmodule

// File: rtl/sm4_byte_round.sv
module sm4_byte_round
   import sm4bs_pkg::*;
#(
   parameter int WORD_W_P = WORD_W,
   parameter int BYTE_W_P = BYTE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [6:0]          funct7,
   input  logic [WORD_W_P-1:0] acc_x,
   input  logic [WORD_W_P-1:0] opnd_a,
   output logic                out_valid,
   output logic [WORD_W_P-1:0] out_result,
   output logic                out_illegal
);
   localparam int LANES = WORD_W_P / BYTE_W_P;
   localparam int SEL_W = $clog2(LANES);

   if (WORD_W_P != 32 || BYTE_W_P != 8) begin : g_chk_geom
      $error("sm4_byte_round: geometry must be 32-bit words of 8-bit lanes");
   end

   logic [SEL_W-1:0]    lane_sel;
   sm4bs_layer_e        layer;
   logic                bad_code;
   logic [BYTE_W_P-1:0] lane_byte [LANES];
   logic [BYTE_W_P-1:0] sub_byte;
   logic [WORD_W_P-1:0] sub_word;
   logic [WORD_W_P-1:0] mixed;
   logic [WORD_W_P-1:0] placed;
   logic [WORD_W_P-1:0] next_res;

   sm4bs_decode #(.SEL_W(SEL_W)) u_dec (
      .code     (funct7),
      .lane_sel (lane_sel),
      .layer    (layer),
      .bad_code (bad_code)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_byte[g] = opnd_a[g*BYTE_W_P +: BYTE_W_P];
   end

   sm4bs_sbox u_sbox (
      .din  (lane_byte[lane_sel]),
      .dout (sub_byte)
   );

   assign sub_word = {{(WORD_W_P-BYTE_W_P){1'b0}}, sub_byte};

   sm4bs_linear #(.W(WORD_W_P)) u_lin (
      .b_in  (sub_word),
      .layer (layer),
      .l_out (mixed)
   );

   always_comb begin
      placed   = rotl(mixed, 32'(lane_sel) * BYTE_W_P);
      next_res = bad_code ? acc_x : (acc_x ^ placed);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid & bad_code;
         if (in_valid) out_result <= next_res;
      end
   end

   assert_issue_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_idle_no_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_bad_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bad_code) |=> (out_illegal && out_result == $past(acc_x)));
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_result));
   assert_flag_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_illegal);
endmodule

// File: tb/sm4_byte_round_tb_top.sv
`timescale 1ns/1ps
module sm4_byte_round_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [6:0]  funct7;
   logic [31:0] acc_x;
   logic [31:0] opnd_a;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_illegal;

   always #10 clk = ~clk;

   sm4_byte_round dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .funct7(funct7),
      .acc_x(acc_x), .opnd_a(opnd_a), .out_valid(out_valid),
      .out_result(out_result), .out_illegal(out_illegal)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [7:0]  sref [256];
   logic [31:0] seed = 32'h9E37_79B9;

   function automatic logic [31:0] xs(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      return t ^ (t << 5);
   endfunction

   function automatic logic [7:0] ref_mul(input logic [7:0] p, input logic [7:0] q);
      logic [15:0] prod;
      prod = '0;
      for (int i = 0; i < 8; i++) if (q[i]) prod = prod ^ (16'(p) << i);
      for (int i = 15; i >= 8; i--) if (prod[i]) prod = prod ^ (16'h01F5 << (i - 8));
      return prod[7:0];
   endfunction

   function automatic logic [7:0] ref_aff(input logic [7:0] v);
      logic [7:0] r;
      logic [7:0] m;
      for (int i = 0; i < 8; i++) begin
         m    = (8'hA7 << i) | (8'hA7 >> (8 - i));
         r[i] = ^(v & m);
      end
      return r ^ 8'hD3;
   endfunction

   function automatic logic [31:0] rl(input logic [31:0] w, input int n);
      return (n == 0) ? w : ((w << n) | (w >> (32 - n)));
   endfunction

   function automatic logic [31:0] lin(input logic [31:0] w, input bit key);
      if (key) return w ^ rl(w, 13) ^ rl(w, 23);
      return w ^ rl(w, 2) ^ rl(w, 10) ^ rl(w, 18) ^ rl(w, 24);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [6:0] f, input logic [31:0] x, input logic [31:0] a);
      @(negedge clk);
      funct7 = f; acc_x = x; opnd_a = a; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] x, a, e, ch, big;
      logic [7:0]  y;
      rst_n = 1'b0; in_valid = 1'b0; funct7 = '0; acc_x = '0; opnd_a = '0;
      for (int v = 0; v < 256; v++) begin
         y = 8'h00;
         for (int c = 1; c < 256; c++) if (ref_mul(ref_aff(8'(v)), 8'(c)) == 8'h01) y = 8'(c);
         sref[v] = ref_aff(y);
      end
      repeat (3) @(negedge clk);
      chk("R10 reset out_valid", 32'(out_valid), 32'd0);
      chk("R10 reset out_result", out_result, 32'd0);
      chk("R10 reset out_illegal", 32'(out_illegal), 32'd0);
      rst_n = 1'b1;

      // R1 spot values of the substitution box, key layer, lane 0
      issue(7'h1A, 32'h0, 32'h0);
      chk("R1 S(00)=D6", out_result, lin(32'hD6, 1'b1));
      issue(7'h1A, 32'h0, 32'h1);
      chk("R1 S(01)=90", out_result, lin(32'h90, 1'b1));

      // R1 R2 R3 R4 full sweep of byte values, lanes and layers
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 256; v++) begin
               seed = xs(seed); x = seed;
               seed = xs(seed); a = seed;
               a[s*8 +: 8] = 8'(v);
               issue({2'(s), 2'b11, 1'b0, 1'(m), 1'b0}, x, a);
               e = x ^ rl(lin({24'h0, sref[v]}, m[0]), s * 8);
               chk(m == 0 ? "R2 R4 round sweep" : "R3 R4 key sweep", out_result, e);
               chk("R7 valid after issue", 32'(out_valid), 32'd1);
               chk("R5 legal code flag", 32'(out_illegal), 32'd0);
            end
         end
      end

      // R5 R6 every function code
      for (int f = 0; f < 128; f++) begin
         seed = xs(seed); x = seed;
         seed = xs(seed); a = seed;
         issue(7'(f), x, a);
         if (f[4:0] == 5'b11000 || f[4:0] == 5'b11010) begin
            e = x ^ rl(lin({24'h0, sref[a[f[6:5]*8 +: 8]]}, f[1]), f[6:5] * 8);
            chk("R5 legal decode result", out_result, e);
            chk("R5 legal decode flag", 32'(out_illegal), 32'd0);
         end else begin
            chk("R6 illegal passthrough", out_result, x);
            chk("R6 illegal flag", 32'(out_illegal), 32'd1);
         end
      end

      // R9 four chained steps equal the whole round transform
      for (int t = 0; t < 8; t++) begin
         logic [31:0] x0, arg;
         seed = xs(seed); x0 = seed;
         seed = xs(seed); arg = seed;
         big = {sref[arg[31:24]], sref[arg[23:16]], sref[arg[15:8]], sref[arg[7:0]]};
         ch = x0;
         for (int s = 0; s < 4; s++) begin
            issue({2'(s), 2'b11, 1'b0, 1'(t % 2), 1'b0}, ch, arg);
            ch = out_result;
         end
         chk("R9 chained round", ch, x0 ^ lin(big, t[0]));
      end

      // R8 idle cycles leave result alone
      issue(7'h38, 32'hCAFE_F00D, 32'h0102_0304);
      e = out_result;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         funct7 = 7'h7A; acc_x = 32'hFFFF_FFFF; opnd_a = 32'h5555_AAAA;
         chk("R8 hold result", out_result, e);
         chk("R8 idle no flag", 32'(out_illegal), 32'd0);
      end
      chk("R7 no valid when idle", 32'(out_valid), 32'd0);

      // R7 back-to-back issue, one result per cycle
      @(negedge clk);
      in_valid = 1'b1; funct7 = 7'h18; acc_x = 32'h1111_1111; opnd_a = 32'h0000_00FF;
      for (int s = 1; s < 5; s++) begin
         e = acc_x ^ rl(lin({24'h0, sref[opnd_a[funct7[6:5]*8 +: 8]]}, funct7[1]), funct7[6:5] * 8);
         @(negedge clk);
         chk("R7 back-to-back result", out_result, e);
         chk("R7 back-to-back valid", 32'(out_valid), 32'd1);
         funct7 = {2'(s % 4), 2'b11, 1'b0, 1'(s % 2), 1'b0};
         acc_x = acc_x + 32'h0101_0101; opnd_a = opnd_a ^ 32'h3C5A_96E1;
      end
      in_valid = 1'b0;
      @(negedge clk);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule